// File: doc/BRIEF.md
# UART status flag controller

This block keeps the eight status flags of a UART-style serial interface. It decides when each flag is set, when it is cleared and when the flags raise an interrupt. The transmit and receive datapaths tell it about events through single-cycle pulses: the transmit holding register has moved into the shifter, a frame has been sent, a received word is ready, the line has gone idle, and the noise, framing and parity qualifiers of the received word. The bus side supplies strobes for accesses to the status register and to the data register, and five interrupt-enable bits.

Software clears a flag with a two-step sequence. First it accesses the status register, then it accesses the data register. A data write clears the transmit flags and a data read clears the receive flags. The block also handles overrun. A word that arrives while the previous one is still unread sets the overrun flag and leaves the receive data register untouched. It re-arms idle detection only after a fresh word has been received. It drives a load strobe for the receive data register, a permit signal for the transmit transfer, and one registered interrupt request.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset, `status` reads 0xC0 and `irq` is low. The bit layout is bit7 tx-empty, bit6 tx-complete, bit5 rx-ready, bit4 idle, bit3 overrun, bit2 noise, bit1 framing, bit0 parity.
- R2: Bits 7 and 6 clear in the cycle after a `data_wr` that follows a `stat_rd` in an earlier cycle. A `data_wr` with no such status access leaves them set.
- R3: Bits 5 to 0 clear in the cycle after a `data_rd` that follows a `stat_rd`. Any data access consumes the armed sequence, so a second data access needs a new `stat_rd`.
- R4: `ev_rx_word` while bit 5 is clear pulses `rdr_load` in the same cycle. In the next cycle it sets bit 5 and copies `rx_noise`, `rx_frame_err` and `rx_parity_err` into bits 2, 1 and 0.
- R5: `ev_rx_word` while bit 5 is set sets bit 3 and keeps `rdr_load` low. Bits 5, 2, 1 and 0 are left unchanged.
- R6: If the overrunning word also carries a framing error, bit 3 is set and bit 1 stays clear.
- R7: `ev_idle` sets bit 4 only if a word has been loaded since the last time bit 4 was set. The first idle after reset is accepted.
- R8: `ev_tx_done` sets bit 6 unless `tx_special` is high in the same cycle. `tx_special` marks a preamble or break frame. `ev_tx_moved` sets bit 7.
- R9: A hardware set of a flag in the same cycle as its software clear wins, and the flag stays set.
- R10: `irq` follows any enabled pair: bit7 with `ie_txe`, bit6 with `ie_txc`, bit5 or bit3 with `ie_rx`, bit4 with `ie_idle`, bit0 with `ie_par`. Bits 2 and 1 never raise `irq`.
- R11: `irq` is registered. It goes low one cycle after the last enabled source flag clears.
- R12: `tx_xfer_ok` is high exactly while bit 7 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_tx_moved | input | 1 | Transmit holding data moved into shifter |
| ev_tx_done | input | 1 | Transmit frame finished |
| tx_special | input | 1 | Finished frame was a preamble or break |
| ev_rx_word | input | 1 | Received word ready to leave the shifter |
| rx_noise | input | 1 | Noise qualifier for the received word |
| rx_frame_err | input | 1 | Framing qualifier for the received word |
| rx_parity_err | input | 1 | Parity qualifier for the received word |
| ev_idle | input | 1 | Idle line seen |
| stat_rd | input | 1 | Status register access strobe |
| data_rd | input | 1 | Data register read strobe |
| data_wr | input | 1 | Data register write strobe |
| ie_txe | input | 1 | Tx-empty interrupt enable |
| ie_txc | input | 1 | Tx-complete interrupt enable |
| ie_rx | input | 1 | Rx-ready and overrun interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| ie_par | input | 1 | Parity interrupt enable |
| status | output | 8 | Status flag byte |
| rdr_load | output | 1 | Load strobe for the receive data register |
| tx_xfer_ok | output | 1 | Transmit transfer to shifter permitted |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the qualifier inputs `rx_noise`, `rx_frame_err`, `rx_parity_err` and `tx_special` matter only in a cycle that carries their event pulse. They also assume a data register access is never a read and a write at once. The stimulus applies every event and strobe for exactly one cycle, changing inputs on the falling clock edge, and raises qualifiers only together with their event. The clear sequences always put the status access in a cycle before the data access, except in the dedicated cases that test a data access with no armed sequence.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
  localparam int FLAG_W   = 8;
  localparam int B_TXE    = 7;
  localparam int B_TXC    = 6;
  localparam int B_RXF    = 5;
  localparam int B_IDL    = 4;
  localparam int B_OVR    = 3;
  localparam int B_NSE    = 2;
  localparam int B_FRM    = 1;
  localparam int B_PAR    = 0;
  localparam logic [FLAG_W-1:0] STATUS_RST = 8'hC0;
endpackage

// File: rtl/uart_flag_seq.sv
// Two-step clear sequencer: a status access arms, the next data access fires and disarms.
module uart_flag_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic stat_rd,
  input  logic data_rd,
  input  logic data_wr,
  output logic rd_clr,
  output logic wr_clr
);
  logic arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (stat_rd)                arm_d = 1'b1;
    else if (data_rd | data_wr) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end

  assign rd_clr = arm_q & data_rd;
  assign wr_clr = arm_q & data_wr;
endmodule

// File: rtl/uart_flag_tx.sv
// Transmit-side flags: holding register empty and transmission complete.
module uart_flag_tx (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_tx_moved,
  input  logic ev_tx_done,
  input  logic tx_special,
  input  logic wr_clr,
  output logic txe,
  output logic txc
);
  logic txe_q, txe_d, txc_q, txc_d, txc_set;

  assign txc_set = ev_tx_done & ~tx_special;

  always_comb begin
    txe_d = ev_tx_moved | (txe_q & ~wr_clr);
    txc_d = txc_set     | (txc_q & ~wr_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_q <= 1'b1;
      txc_q <= 1'b1;
    end else begin
      txe_q <= txe_d;
      txc_q <= txc_d;
    end
  end

  assign txe = txe_q;
  assign txc = txc_q;
endmodule

// File: rtl/uart_flag_rx.sv
// Receive-side flags: ready, idle, overrun and the error qualifiers.
module uart_flag_rx (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_rx_word,
  input  logic rx_noise,
  input  logic rx_frame_err,
  input  logic rx_parity_err,
  input  logic ev_idle,
  input  logic rd_clr,
  output logic rxf,
  output logic idl,
  output logic ovr,
  output logic nse,
  output logic frm,
  output logic par,
  output logic load
);
  logic rxf_q, idl_q, ovr_q, nse_q, frm_q, par_q, rearm_q;
  logic rxf_d, idl_d, ovr_d, nse_d, frm_d, par_d, rearm_d;
  logic ld, ovr_set, idl_set, keep;

  // A word is loaded only into an empty receive register; otherwise it overruns.
  assign ld      = ev_rx_word & ~rxf_q;
  assign ovr_set = ev_rx_word &  rxf_q;
  assign idl_set = ev_idle & rearm_q;
  assign keep    = ~rd_clr;

  always_comb begin
    rxf_d   = ld | (rxf_q & keep);
    ovr_d   = ovr_set | (ovr_q & keep);
    nse_d   = (ld & rx_noise)      | (nse_q & keep);
    frm_d   = (ld & rx_frame_err)  | (frm_q & keep);
    par_d   = (ld & rx_parity_err) | (par_q & keep);
    idl_d   = idl_set | (idl_q & keep);
    rearm_d = rearm_q;
    if (ld)           rearm_d = 1'b1;
    else if (idl_set) rearm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q   <= 1'b0;
      idl_q   <= 1'b0;
      ovr_q   <= 1'b0;
      nse_q   <= 1'b0;
      frm_q   <= 1'b0;
      par_q   <= 1'b0;
      rearm_q <= 1'b1;
    end else begin
      rxf_q   <= rxf_d;
      idl_q   <= idl_d;
      ovr_q   <= ovr_d;
      nse_q   <= nse_d;
      frm_q   <= frm_d;
      par_q   <= par_d;
      rearm_q <= rearm_d;
    end
  end

  assign rxf  = rxf_q;
  assign idl  = idl_q;
  assign ovr  = ovr_q;
  assign nse  = nse_q;
  assign frm  = frm_q;
  assign par  = par_q;
  assign load = ld;
endmodule

// File: rtl/uart_flag_irq.sv
// Registered interrupt combiner; noise and framing flags are not sources.
module uart_flag_irq
  import uart_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags,
  input  logic              ie_txe,
  input  logic              ie_txc,
  input  logic              ie_rx,
  input  logic              ie_idle,
  input  logic              ie_par,
  output logic              irq
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = (flags[B_TXE] & ie_txe)
          | (flags[B_TXC] & ie_txc)
          | ((flags[B_RXF] | flags[B_OVR]) & ie_rx)
          | (flags[B_IDL] & ie_idle)
          | (flags[B_PAR] & ie_par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq = irq_q;
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
  import uart_flag_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_tx_moved,
  input  logic              ev_tx_done,
  input  logic              tx_special,
  input  logic              ev_rx_word,
  input  logic              rx_noise,
  input  logic              rx_frame_err,
  input  logic              rx_parity_err,
  input  logic              ev_idle,
  input  logic              stat_rd,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ie_txe,
  input  logic              ie_txc,
  input  logic              ie_rx,
  input  logic              ie_idle,
  input  logic              ie_par,
  output logic [FLAG_W-1:0] status,
  output logic              rdr_load,
  output logic              tx_xfer_ok,
  output logic              irq
);
  // Reset asserts asynchronously and is released on a clock edge.
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic rd_clr, wr_clr;
  logic txe, txc, rxf, idl, ovr, nse, frm, par;
  logic [FLAG_W-1:0] flags;

  uart_flag_seq u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
    .rd_clr(rd_clr), .wr_clr(wr_clr)
  );

  uart_flag_tx u_tx (
    .clk(clk), .rst_n(rst_int_n),
    .ev_tx_moved(ev_tx_moved), .ev_tx_done(ev_tx_done), .tx_special(tx_special),
    .wr_clr(wr_clr), .txe(txe), .txc(txc)
  );

  uart_flag_rx u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .ev_rx_word(ev_rx_word), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err),
    .rx_parity_err(rx_parity_err), .ev_idle(ev_idle), .rd_clr(rd_clr),
    .rxf(rxf), .idl(idl), .ovr(ovr), .nse(nse), .frm(frm), .par(par),
    .load(rdr_load)
  );

  always_comb begin
    flags        = '0;
    flags[B_TXE] = txe;
    flags[B_TXC] = txc;
    flags[B_RXF] = rxf;
    flags[B_IDL] = idl;
    flags[B_OVR] = ovr;
    flags[B_NSE] = nse;
    flags[B_FRM] = frm;
    flags[B_PAR] = par;
  end

  uart_flag_irq u_irq (
    .clk(clk), .rst_n(rst_int_n), .flags(flags),
    .ie_txe(ie_txe), .ie_txc(ie_txc), .ie_rx(ie_rx),
    .ie_idle(ie_idle), .ie_par(ie_par), .irq(irq)
  );

  assign status     = flags;
  assign tx_xfer_ok = ~txe;
endmodule

// File: rtl/uart_flag_ctrl_chk.sv
module uart_flag_ctrl_chk
  import uart_flag_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ev_tx_done,
  input logic              tx_special,
  input logic              ev_rx_word,
  input logic              data_rd,
  input logic              data_wr,
  input logic              ie_txe,
  input logic              ie_txc,
  input logic              ie_rx,
  input logic              ie_idle,
  input logic              ie_par,
  input logic [FLAG_W-1:0] status,
  input logic              rdr_load,
  input logic              irq
);
  logic any_ie;
  assign any_ie = ie_txe | ie_txc | ie_rx | ie_idle | ie_par;

  AST_TXE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_TXE] && !data_wr |=> status[B_TXE]); // R2
  AST_RXF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_RXF] && !data_rd |=> status[B_RXF]); // R3
  AST_LOAD_SETS_RXF: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_load |=> status[B_RXF]); // R4
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_word && status[B_RXF] |=> status[B_OVR]); // R5
  AST_OVERRUN_NO_FE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_word && status[B_RXF] && !status[B_FRM] |=> !status[B_FRM]); // R6
  AST_SPECIAL_NO_TC: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done && tx_special && !status[B_TXC] |=> !status[B_TXC]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ie |=> !irq); // R10
endmodule

bind uart_flag_ctrl uart_flag_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_tx_done(ev_tx_done), .tx_special(tx_special),
  .ev_rx_word(ev_rx_word), .data_rd(data_rd), .data_wr(data_wr),
  .ie_txe(ie_txe), .ie_txc(ie_txc), .ie_rx(ie_rx), .ie_idle(ie_idle),
  .ie_par(ie_par), .status(status), .rdr_load(rdr_load), .irq(irq)
);

// File: tb/uart_flag_ctrl_bench.sv
module uart_flag_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_tx_moved = 0, ev_tx_done = 0, tx_special = 0;
  logic ev_rx_word = 0, rx_noise = 0, rx_frame_err = 0, rx_parity_err = 0;
  logic ev_idle = 0, stat_rd = 0, data_rd = 0, data_wr = 0;
  logic ie_txe = 0, ie_txc = 0, ie_rx = 0, ie_idle = 0, ie_par = 0;
  logic [7:0] status;
  logic rdr_load, tx_xfer_ok, irq;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_flag_ctrl u_uart_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_tx_moved(ev_tx_moved), .ev_tx_done(ev_tx_done),
    .tx_special(tx_special), .ev_rx_word(ev_rx_word), .rx_noise(rx_noise),
    .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err), .ev_idle(ev_idle),
    .stat_rd(stat_rd), .data_rd(data_rd), .data_wr(data_wr),
    .ie_txe(ie_txe), .ie_txc(ie_txc), .ie_rx(ie_rx), .ie_idle(ie_idle), .ie_par(ie_par),
    .status(status), .rdr_load(rdr_load), .tx_xfer_ok(tx_xfer_ok), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // One-cycle strobes, applied on a falling edge, result visible at the next one.
  task automatic do_stat();  stat_rd = 1; tick(); stat_rd = 0; endtask
  task automatic do_rd();    data_rd = 1; tick(); data_rd = 0; endtask
  task automatic do_wr();    data_wr = 1; tick(); data_wr = 0; endtask
  task automatic do_idle();  ev_idle = 1; tick(); ev_idle = 0; endtask

  task automatic do_word(input logic n, input logic f, input logic p, input logic exp_load,
                         input string req);
    ev_rx_word = 1; rx_noise = n; rx_frame_err = f; rx_parity_err = p;
    #1 chk(req, {7'd0, rdr_load}, {7'd0, exp_load});
    tick();
    ev_rx_word = 0; rx_noise = 0; rx_frame_err = 0; rx_parity_err = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'hC0);
    chk("R1 irq", {7'd0, irq}, 8'd0);
    chk("R12 xfer_ok", {7'd0, tx_xfer_ok}, 8'd0);
  endtask

  task automatic t_tx();
    do_wr();
    chk("R2 unarmed write", status, 8'hC0);
    do_stat(); do_wr();
    chk("R2 armed write", status, 8'h00);
    chk("R12 xfer_ok high", {7'd0, tx_xfer_ok}, 8'd1);
    ev_tx_moved = 1; tick(); ev_tx_moved = 0;
    chk("R8 moved sets txe", status, 8'h80);
    chk("R12 xfer_ok low", {7'd0, tx_xfer_ok}, 8'd0);
    ev_tx_done = 1; tx_special = 1; tick(); ev_tx_done = 0; tx_special = 0;
    chk("R8 special frame", status, 8'h80);
    ev_tx_done = 1; tick(); ev_tx_done = 0;
    chk("R8 normal frame", status, 8'hC0);
  endtask

  task automatic t_rx();
    do_word(1, 0, 0, 1, "R4 load pulse");
    chk("R4 word with noise", status, 8'hE4);
    do_rd();
    chk("R3 unarmed read", status, 8'hE4);
    do_stat(); do_wr();
    chk("R3 write clears tx only", status, 8'h24);
    do_rd();
    chk("R3 arm consumed", status, 8'h24);
    ev_tx_moved = 1; ev_tx_done = 1; tick(); ev_tx_moved = 0; ev_tx_done = 0;
    do_stat(); do_rd();
    chk("R3 armed read", status, 8'hC0);
    do_word(0, 1, 1, 1, "R4 load pulse 2");
    chk("R4 frame+parity", status, 8'hE3);
    do_stat(); do_rd();
    chk("R3 clear 2", status, 8'hC0);
  endtask

  task automatic t_overrun();
    do_word(0, 0, 0, 1, "R4 load pulse 3");
    chk("R4 plain word", status, 8'hE0);
    do_word(1, 1, 1, 0, "R5 no load on overrun");
    chk("R6 overrun only", status, 8'hE8);
    do_stat(); do_rd();
    chk("R5 overrun cleared", status, 8'hC0);
  endtask

  task automatic t_idle();
    do_idle();
    chk("R7 first idle", status, 8'hD0);
    do_stat(); do_rd();
    chk("R7 idle cleared", status, 8'hC0);
    do_idle();
    chk("R7 idle blocked", status, 8'hC0);
    do_word(0, 0, 0, 1, "R7 load");
    do_stat(); do_rd();
    do_idle();
    chk("R7 idle rearmed", status, 8'hD0);
    do_stat(); do_rd();
    chk("R7 cleared again", status, 8'hC0);
  endtask

  task automatic t_set_wins();
    do_stat();
    data_rd = 1; ev_rx_word = 1; tick(); data_rd = 0; ev_rx_word = 0;
    chk("R9 rx set beats clear", status, 8'hE0);
    do_stat();
    data_wr = 1; ev_tx_moved = 1; tick(); data_wr = 0; ev_tx_moved = 0;
    chk("R9 txe set beats clear", status, 8'hA0);
    do_stat(); do_rd();
    chk("R9 cleanup", status, 8'h80);
  endtask

  task automatic t_irq();
    ie_txe = 1; tick();
    chk("R10 txe irq", {7'd0, irq}, 8'd1);
    do_stat(); do_wr();
    chk("R11 flag clear", status, 8'h00);
    chk("R11 irq one cycle late", {7'd0, irq}, 8'd1);
    tick();
    chk("R11 irq dropped", {7'd0, irq}, 8'd0);
    ie_txc = 1; ie_idle = 1; ie_par = 1;
    do_word(1, 1, 0, 1, "R10 load");
    tick();
    chk("R10 noise/frame silent", {7'd0, irq}, 8'd0);
    ie_rx = 1; tick(); tick();
    chk("R10 rx irq", {7'd0, irq}, 8'd1);
    ie_rx = 0;
    do_stat(); do_rd();
    do_word(0, 0, 1, 1, "R10 load 2");
    tick();
    chk("R10 parity irq", {7'd0, irq}, 8'd1);
    ie_txe = 0; ie_txc = 0; ie_idle = 0; ie_par = 0;
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1;
    repeat (4) tick();
    t_reset();
    t_tx();
    t_rx();
    t_overrun();
    t_idle();
    t_set_wins();
    t_irq();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule